// File: doc/BRIEF.md
# Sequenced-Key Watchdog Timer

This block watches for a stalled program and requests a system reset when software fails to service it in time. Software selects a timeout with a three-bit control field, or turns the block off. While the block is enabled, a counter advances on each timebase tick. If the counter reaches the selected limit, the block issues a one-cycle reset request.

To service the block, software writes a two-byte key to the service register. The arming byte 0x55 must come first and the restart byte 0xAA second. Any other byte written to the service register while the block is enabled is treated as a sign of runaway code and produces an immediate reset request. A sticky flag records whether the most recent request came from a timeout or from a bad key.

Both registers share one write port with a one-bit address. The timebase tick comes from an external prescaler. The reset request goes to a reset controller, which stretches the pulse as needed.

Top module: `wdt_seqkey`

## Requirements
- R1: After `rst`, the select field is 000, the counter is zero, the sequence is disarmed, `rst_req` is 0 and `cause_bad_key` is 0, so the watchdog starts disabled.
- R2: A write with `wr_addr`=0 loads `wr_data[2:0]` into the select field. While the select field is 000, the counter is held at zero and no timeout request is produced.
- R3: With select value n (1 to 7), `rst_req` is high for one cycle, in the cycle after the clock edge that samples the 2^(BASE_EXP+STEP*(n-1))-th tick since the last restart. The defaults are BASE_EXP=13 and STEP=2.
- R4: A service write (`wr_addr`=1) of 0x55 arms the sequence, and further 0x55 writes keep it armed.
- R5: A service write of 0xAA while armed restarts the counter at zero and disarms the sequence. A service write of 0xAA while disarmed has no effect.
- R6: While enabled, a service write of any byte other than 0x55 or 0xAA sets `rst_req` in the next cycle with `cause_bad_key`=1. It also clears the counter and disarms the sequence.
- R7: Each request lasts one cycle. `cause_bad_key` is 1 for a bad key and 0 for a timeout, and it changes only when a request is issued.
- R8: While disabled, service writes are ignored: they neither arm the sequence nor produce a request.
- R9: A valid restart in the same cycle as the final tick prevents the timeout. A bad key in the same cycle as the final tick gives a single request with `cause_bad_key`=1.
- R10: After a timeout request, the counter restarts from zero and the sequence is disarmed.
- R11: If the select field is lowered while the counter is already at or past the new limit, the next tick produces a timeout request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control (select field), 1 = service register |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Timebase tick, one cycle wide |
| rst_req | output | 1 | One-cycle system reset request |
| cause_bad_key | output | 1 | Sticky cause of the last request: 1 bad key, 0 timeout |

## Verification
The hardest situations to reach are the same-cycle collisions, where a restart byte or a bad byte lands on the exact tick that would expire the counter. The bench counts ticks from a known restart and places the service write on the final tick. It also places a bad key on that tick. With a small bench configuration the limits are 4 to 256 ticks, so every select value can be swept to its exact expiry edge. The same configuration also allows a sweep over all 254 bad key bytes.

// File: rtl/wdt_seqkey_pkg.sv
package wdt_seqkey_pkg;

    localparam int unsigned SEL_W    = 3;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NUM_SEL  = (1 << SEL_W) - 1;

    localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_FIRE = 8'hAA;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_SVC  = 1'b1
    } wdt_addr_e;

    typedef enum logic {
        CAUSE_TIMEOUT = 1'b0,
        CAUSE_BADKEY  = 1'b1
    } wdt_cause_e;

    typedef struct packed {
        logic restart;
        logic bad;
    } key_evt_t;

    // Exponent of the timeout length for a select value (0 when disabled).
    function automatic int unsigned tmo_exp(logic [SEL_W-1:0] s,
                                            int unsigned base,
                                            int unsigned step);
        if (s == '0) return 0;
        return base + step * (32'(s) - 32'd1);
    endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_seqkey_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] data,
    input  logic              drop,
    output key_evt_t          evt,
    output logic              armed
);

    logic is_arm, is_fire;

    assign is_arm      = (data == KEY_ARM);
    assign is_fire     = (data == KEY_FIRE);
    assign evt.restart = svc_wr & is_fire & armed;
    assign evt.bad     = svc_wr & ~is_arm & ~is_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (drop || evt.bad || evt.restart) begin
            armed <= 1'b0;
        end else if (svc_wr && is_arm) begin
            armed <= 1'b1;
        end
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int unsigned CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    logic at_end;

    // ">=" so that a lowered limit still expires on the next tick.
    assign at_end = (count >= limit - CNT_W'(1));
    assign expire = en & tick & at_end & ~clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (!en || clr || expire) begin
            count <= '0;
        end else if (tick) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt_seqkey.sv
module wdt_seqkey
    import wdt_seqkey_pkg::*;
#(
    parameter int unsigned BASE_EXP = 13,
    parameter int unsigned STEP     = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        tick,
    output logic        rst_req,
    output logic        cause_bad_key
);

    localparam int unsigned CNT_W = BASE_EXP + STEP * (NUM_SEL - 1) + 1;

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;
    logic             en, svc_wr, ctrl_wr, expire, fire, armed;
    key_evt_t         evt;
    wdt_cause_e       cause_q;

    assign en      = (sel_q != '0);
    assign ctrl_wr = wr_en & (wr_addr == ADDR_CTRL);
    assign svc_wr  = wr_en & (wr_addr == ADDR_SVC) & en;

    always_comb begin
        if (!en) limit = '0;
        else     limit = CNT_W'(1) << tmo_exp(sel_q, BASE_EXP, STEP);
    end

    always_ff @(posedge clk) begin
        if (rst)          sel_q <= '0;
        else if (ctrl_wr) sel_q <= wr_data[SEL_W-1:0];
    end

    wdt_key_seq u_keys (
        .clk    (clk),
        .rst    (rst),
        .svc_wr (svc_wr),
        .data   (wr_data),
        .drop   (expire | ~en),
        .evt    (evt),
        .armed  (armed)
    );

    wdt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (tick),
        .clr    (evt.restart | evt.bad),
        .limit  (limit),
        .expire (expire),
        .count  (count)
    );

    assign fire = expire | evt.bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
            cause_q <= CAUSE_TIMEOUT;
        end else begin
            rst_req <= fire;
            if (fire) cause_q <= evt.bad ? CAUSE_BADKEY : CAUSE_TIMEOUT;
        end
    end

    assign cause_bad_key = (cause_q == CAUSE_BADKEY);

endmodule

// File: rtl/wdt_seqkey_chk.sv
module wdt_seqkey_chk #(
    parameter int unsigned CNT_W = 26
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [7:0]       wr_data,
    input logic             tick,
    input logic             rst_req,
    input logic             cause_bad_key,
    input logic [2:0]       sel_q,
    input logic             armed,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] limit
);

    logic svc_on;
    assign svc_on = wr_en && wr_addr && (sel_q != 3'd0);

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_q) == 3'd0) |-> !rst_req); // R2

    AST_ARM_KEY: assert property (@(posedge clk) disable iff (rst)
        (svc_on && wr_data == 8'h55 && !(tick && count >= limit - 1'b1)) |=> armed); // R4

    AST_KEY_RESTART: assert property (@(posedge clk) disable iff (rst)
        (svc_on && armed && wr_data == 8'hAA) |=> (count == '0 && !armed)); // R5

    AST_BAD_KEY_RESET: assert property (@(posedge clk) disable iff (rst)
        (svc_on && wr_data != 8'h55 && wr_data != 8'hAA) |=> (rst_req && cause_bad_key)); // R6

    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rst_req |-> $stable(cause_bad_key)); // R7

    AST_DISABLED_UNARMED: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_q) == 3'd0) |-> !armed); // R8

endmodule

bind wdt_seqkey wdt_seqkey_chk #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .tick          (tick),
    .rst_req       (rst_req),
    .cause_bad_key (cause_bad_key),
    .sel_q         (sel_q),
    .armed         (armed),
    .count         (count),
    .limit         (limit)
);

// File: tb/wdt_seqkey_tb_top.sv
module wdt_seqkey_tb_top;

    localparam int BASE_EXP = 2;
    localparam int STEP     = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b0;
    logic       rst_req, cause_bad_key;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wdt_seqkey #(.BASE_EXP(BASE_EXP), .STEP(STEP)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .tick          (tick),
        .rst_req       (rst_req),
        .cause_bad_key (cause_bad_key)
    );

    function automatic int lim(int n);
        return 1 << (BASE_EXP + STEP * (n - 1));
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle; on return the outputs reflect that cycle's edge.
    task automatic cyc(logic we, logic ad, logic [7:0] d, logic tk);
        wr_en = we; wr_addr = ad; wr_data = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic sel_set(int n);
        cyc(1'b1, 1'b0, 8'(n), 1'b0);
    endtask

    task automatic svc(logic [7:0] d);
        cyc(1'b1, 1'b1, d, 1'b0);
    endtask

    task automatic restart();
        svc(8'h55);
        svc(8'hAA);
        chk("R5 restart quiet", rst_req, 1'b0);
    endtask

    task automatic run_ticks(int n, string req);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b0, 8'h00, 1'b1);
            chk(req, rst_req, 1'b0);
        end
    endtask

    task automatic last_tick(string req);
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        chk(req, rst_req, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rst_req", rst_req, 1'b0);
        chk("R1 cause", cause_bad_key, 1'b0);

        // R1/R2: disabled out of reset, ticks never time out
        run_ticks(300, "R2 disabled after reset");

        // R8: service writes ignored while disabled
        svc(8'h00);
        chk("R8 bad byte ignored", rst_req, 1'b0);
        svc(8'h55);
        sel_set(1);
        run_ticks(2, "R8");
        svc(8'hAA);
        chk("R8 AA after ignored arm", rst_req, 1'b0);
        run_ticks(1, "R8");
        last_tick("R8 no arm while disabled");

        // R3/R7/R10: every select value, exact expiry edge, twice
        for (int n = 1; n <= 7; n++) begin
            sel_set(n);
            restart();
            run_ticks(lim(n) - 1, "R3 early");
            last_tick("R3 expiry");
            chk("R7 cause timeout", cause_bad_key, 1'b0);
            cyc(1'b0, 1'b0, 8'h00, 1'b0);
            chk("R7 one cycle", rst_req, 1'b0);
            run_ticks(lim(n) - 1, "R10 early");
            last_tick("R10 expiry after request");
        end

        // R5: AA while disarmed has no effect
        sel_set(1);
        restart();
        run_ticks(2, "R5");
        svc(8'hAA);
        chk("R5 unarmed AA", rst_req, 1'b0);
        run_ticks(1, "R5");
        last_tick("R5 unarmed AA no restart");

        // R4: repeated arming byte
        restart();
        run_ticks(3, "R4");
        svc(8'h55);
        svc(8'h55);
        svc(8'hAA);
        chk("R4 restart", rst_req, 1'b0);
        run_ticks(3, "R4 after restart");
        last_tick("R4 expiry");

        // R6/R7: every bad byte
        for (int b = 0; b < 256; b++) begin
            if (b == 8'h55 || b == 8'hAA) continue;
            svc(8'(b));
            chk("R6 bad key req", rst_req, 1'b1);
            chk("R6 bad key cause", cause_bad_key, 1'b1);
            cyc(1'b0, 1'b0, 8'h00, 1'b0);
            chk("R7 one cycle", rst_req, 1'b0);
            chk("R7 cause held", cause_bad_key, 1'b1);
        end
        run_ticks(3, "R6 counter cleared");
        last_tick("R7 timeout after bad");
        chk("R7 cause to timeout", cause_bad_key, 1'b0);

        // R6: bad byte disarms
        svc(8'h55);
        svc(8'h00);
        chk("R6 bad after arm", rst_req, 1'b1);
        svc(8'hAA);
        chk("R6 AA after bad", rst_req, 1'b0);
        run_ticks(3, "R6");
        last_tick("R6 disarmed");

        // R9: restart on final tick wins
        restart();
        run_ticks(3, "R9");
        svc(8'h55);
        cyc(1'b1, 1'b1, 8'hAA, 1'b1);
        chk("R9 restart beats tick", rst_req, 1'b0);
        run_ticks(3, "R9");
        last_tick("R9 after restart");

        // R9: bad key on final tick
        restart();
        run_ticks(3, "R9");
        cyc(1'b1, 1'b1, 8'h00, 1'b1);
        chk("R9 collision req", rst_req, 1'b1);
        chk("R9 collision cause", cause_bad_key, 1'b1);
        cyc(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R9 single pulse", rst_req, 1'b0);

        // R11: lowering the select past the count
        sel_set(7);
        restart();
        run_ticks(20, "R11");
        sel_set(1);
        last_tick("R11 lowered limit");
        chk("R11 cause", cause_bad_key, 1'b0);

        // R2: disabling holds the counter at zero
        restart();
        run_ticks(3, "R2");
        sel_set(0);
        run_ticks(10, "R2 disabled");
        sel_set(1);
        run_ticks(3, "R2 re-enabled");
        last_tick("R2 count restarted");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule